// File: doc/BRIEF.md
# Guarded Single-Precision Equality Unit

This execution unit compares two IEEE-754 single-precision operands for equality and returns an integer: 1 when the values are equal, 0 when they are not. A subnormal operand is read as zero before the comparison, and a dedicated status bit records that this substitution happened. Any NaN operand makes the result 0. A signaling NaN also raises the invalid-operation bit. A quiet NaN raises nothing.

Each operation is predicated on the least significant bit of a 32-bit guard word. When that bit is 1, the unit writes the destination and updates the status bits one clock later. When it is 0, neither changes. The status bits are sticky: once set, a bit stays set until an explicit status write replaces the whole register. Other functional units that finish in the same cycle present their own flag updates on a side input. The unit ORs those updates with its own and with the current register value.

Top module: `fp_eq_unit`

## Requirements
- R1: The result value is 32'd1 when the operands are equal as floats and 32'd0 otherwise; bits 31:1 are always zero when a result is written.
- R2: An issued operation with guard bit 0 set drives `res_we` high for exactly the cycle after the issuing edge (latency 1). The new `res_data` and the status update appear at that same edge.
- R3: When `guard[0]` is 0, `res_we` stays low, `res_data` keeps its previous value, and the operation changes no status bit.
- R4: An operand whose exponent field is 0 and whose fraction is nonzero is treated as zero. It sets status bit 5 (flush-to-zero), so 1.0 compared with 0x00400000 gives 0 with bit 5 set.
- R5: +0 and -0 compare equal. A flushed subnormal compares equal to either zero and to another flushed subnormal.
- R6: A NaN operand (exponent 0xFF, fraction nonzero) gives 0. A signaling NaN (fraction bit 22 clear) sets status bit 0 (invalid). A quiet NaN (fraction bit 22 set) leaves bit 0 unchanged.
- R7: +inf equals +inf (result 1). +inf compared with -inf gives 0.
- R8: Status bits are sticky. Without a status write, no bit that is 1 ever returns to 0, across any number of cycles.
- R9: On each clock edge, every status bit becomes the OR of its current value, the unit's own update and the matching bit of `ext_flags`. Status bit map: 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 flush-to-zero.
- R10: When `stat_we` is high, `status` takes `stat_wdata` at the next edge. This write overrides the unit's own update and `ext_flags` in that same cycle.
- R11: After reset, `res_we` is 0, `res_data` is 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue strobe for a comparison |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| guard | input | 32 | Guard word; bit 0 predicates the operation |
| ext_flags | input | 6 | Flag updates from other units in this cycle |
| stat_we | input | 1 | Explicit status register write |
| stat_wdata | input | 6 | Value written to the status register |
| res_data | output | 32 | Integer comparison result |
| res_we | output | 1 | Destination write enable |
| status | output | 6 | Sticky exception status bits |

## Verification
A wrong comparison or a wrong operand class shows at the port as the wrong `res_data` value one cycle after issue. A wrong guard decode shows the same way, through a `res_we` pulse that should not appear or a result that should not change. A fault in the sticky register shows as a status bit that appears or disappears. This can happen on the same edge as the operation, or on any later idle cycle, if a bit decays or a write loses priority. The bench therefore samples status right after each operation and again after several idle cycles.

// File: rtl/fp_eq_unit.sv
module fp_eq_unit #(
  parameter int W    = 32,
  parameter int FL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [W-1:0]    guard,
  input  logic [FL_W-1:0] ext_flags,
  input  logic            stat_we,
  input  logic [FL_W-1:0] stat_wdata,
  output logic [W-1:0]    res_data,
  output logic            res_we,
  output logic [FL_W-1:0] status
);
  localparam int EXP_W = 8;
  localparam int FRC_W = W - EXP_W - 1;
  localparam int B_INV = 0;
  localparam int B_FTZ = 5;

  logic [EXP_W-1:0] ea, eb;
  logic [FRC_W-1:0] fa, fb;
  logic sub_a, sub_b, zer_a, zer_b, nan_a, nan_b, snan_a, snan_b;
  logic same, go;
  logic [FL_W-1:0] own;

  assign ea = op_a[W-2 -: EXP_W];
  assign eb = op_b[W-2 -: EXP_W];
  assign fa = op_a[FRC_W-1:0];
  assign fb = op_b[FRC_W-1:0];

  assign sub_a  = (ea == '0) && (fa != '0);
  assign sub_b  = (eb == '0) && (fb != '0);
  assign zer_a  = (ea == '0);
  assign zer_b  = (eb == '0);
  assign nan_a  = (&ea) && (fa != '0);
  assign nan_b  = (&eb) && (fb != '0);
  assign snan_a = nan_a && !fa[FRC_W-1];
  assign snan_b = nan_b && !fb[FRC_W-1];

  assign same = !nan_a && !nan_b && ((zer_a && zer_b) || (op_a == op_b));
  assign go   = op_valid && guard[0];

  always_comb begin
    own        = '0;
    own[B_INV] = snan_a || snan_b;
    own[B_FTZ] = sub_a || sub_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data <= '0;
      res_we   <= 1'b0;
      status   <= '0;
    end else begin
      res_we <= go;
      if (go) res_data <= {{(W-1){1'b0}}, same};
      if (stat_we)
        status <= stat_wdata;
      else
        status <= status | ext_flags | (go ? own : '0);
    end
  end
endmodule

// File: rtl/fp_eq_unit_chk.sv
module fp_eq_unit_chk #(
  parameter int W    = 32,
  parameter int FL_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [W-1:0]    op_a,
  input logic [W-1:0]    op_b,
  input logic [W-1:0]    guard,
  input logic [FL_W-1:0] ext_flags,
  input logic            stat_we,
  input logic [FL_W-1:0] stat_wdata,
  input logic [W-1:0]    res_data,
  input logic            res_we,
  input logic [FL_W-1:0] status
);
  // R1
  r1_res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_data[W-1:1] == '0));
  // R2
  r2_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && guard[0]) |=> res_we);
  // R3
  r3_no_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> $past(op_valid && guard[0]));
  // R3
  r3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_we |-> $stable(res_data));
  // R4
  r4_ftz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && guard[0] && !stat_we &&
     (op_a[W-2 -: 8] == 8'd0) && (op_a[W-10:0] != '0)) |=> status[5]);
  // R8
  r8_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_we) |-> ((status & $past(status)) == $past(status)));
  // R10
  r10_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (status == $past(stat_wdata)));
endmodule

bind fp_eq_unit fp_eq_unit_chk #(.W(W), .FL_W(FL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
  .guard(guard), .ext_flags(ext_flags), .stat_we(stat_we),
  .stat_wdata(stat_wdata), .res_data(res_data), .res_we(res_we),
  .status(status)
);

// File: tb/fp_eq_unit_tb.sv
module fp_eq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, guard = '0;
  logic [5:0]  ext_flags = '0;
  logic        stat_we = 1'b0;
  logic [5:0]  stat_wdata = '0;
  logic [31:0] res_data;
  logic        res_we;
  logic [5:0]  status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] P3   = 32'h40400000;
  localparam logic [31:0] P1   = 32'h3f800000;
  localparam logic [31:0] PZ   = 32'h00000000;
  localparam logic [31:0] NZ   = 32'h80000000;
  localparam logic [31:0] QN   = 32'hffffffff;
  localparam logic [31:0] SN   = 32'h7fa00000;
  localparam logic [31:0] PINF = 32'h7f800000;
  localparam logic [31:0] NINF = 32'hff800000;
  localparam logic [31:0] DN1  = 32'h00400000;
  localparam logic [31:0] DN2  = 32'h80000001;

  always #2.5 clk = ~clk;

  fp_eq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .guard(guard), .ext_flags(ext_flags), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .res_data(res_data), .res_we(res_we),
    .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic g, input logic [5:0] ext,
                       input logic swe, input logic [5:0] swd, input logic v);
    op_a = a; op_b = b; guard = {31'h1234abc, g}; ext_flags = ext;
    stat_we = swe; stat_wdata = swd; op_valid = v;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; ext_flags = '0; stat_we = 1'b0; guard = '0;
  endtask

  task automatic set_status(input logic [5:0] v);
    issue(PZ, PZ, 1'b0, 6'h0, 1'b1, v, 1'b0);
  endtask

  task automatic cmp(input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp, input string req, input string what);
    issue(a, b, 1'b1, 6'h0, 1'b0, 6'h0, 1'b1);
    chk(res_we === 1'b1, "R2", {what, " we"}, {31'h0, res_we}, 32'h1);
    chk(res_data === exp, req, what, res_data, exp);
  endtask

  task automatic t_reset;
    chk(res_we === 1'b0, "R11", "reset we", {31'h0, res_we}, 32'h0);
    chk(res_data === 32'h0, "R11", "reset data", res_data, 32'h0);
    chk(status === 6'h0, "R11", "reset status", {26'h0, status}, 32'h0);
  endtask

  task automatic t_basic;
    cmp(P3, PZ, 32'd0, "R1", "3.0 vs 0.0");
    cmp(P3, P3, 32'd1, "R1", "3.0 vs 3.0");
    cmp(P3, P1, 32'd0, "R1", "3.0 vs 1.0");
    @(negedge clk);
    chk(res_we === 1'b0, "R2", "we one cycle only", {31'h0, res_we}, 32'h0);
    chk(status === 6'h0, "R1", "no flags for normals", {26'h0, status}, 32'h0);
  endtask

  task automatic t_guard;
    cmp(P3, P3, 32'd1, "R1", "preload 1");
    set_status(6'h0);
    issue(P1, DN1, 1'b0, 6'h0, 1'b0, 6'h0, 1'b1);
    chk(res_we === 1'b0, "R3", "guard off we", {31'h0, res_we}, 32'h0);
    chk(res_data === 32'd1, "R3", "guard off data held", res_data, 32'd1);
    chk(status === 6'h0, "R3", "guard off status", {26'h0, status}, 32'h0);
    issue(P1, P3, 1'b1, 6'h0, 1'b0, 6'h0, 1'b1);
    chk(res_data === 32'd0, "R3", "guard on writes", res_data, 32'd0);
  endtask

  task automatic t_denorm;
    set_status(6'h0);
    cmp(P1, DN1, 32'd0, "R4", "1.0 vs subnormal");
    chk(status === 6'h20, "R4", "ftz bit", {26'h0, status}, 32'h20);
    set_status(6'h0);
    cmp(PZ, NZ, 32'd1, "R5", "+0 vs -0");
    chk(status === 6'h0, "R5", "zeros no ftz", {26'h0, status}, 32'h0);
    cmp(DN1, DN2, 32'd1, "R5", "subnormal vs subnormal");
    cmp(NZ, DN1, 32'd1, "R5", "-0 vs subnormal");
    chk(status === 6'h20, "R4", "ftz after flush", {26'h0, status}, 32'h20);
  endtask

  task automatic t_nan;
    set_status(6'h0);
    cmp(P3, QN, 32'd0, "R6", "3.0 vs qNaN");
    cmp(QN, QN, 32'd0, "R6", "qNaN vs qNaN");
    chk(status === 6'h0, "R6", "qNaN no invalid", {26'h0, status}, 32'h0);
    cmp(SN, SN, 32'd0, "R6", "sNaN vs sNaN");
    chk(status === 6'h01, "R6", "sNaN invalid", {26'h0, status}, 32'h1);
  endtask

  task automatic t_inf;
    cmp(PINF, NINF, 32'd0, "R7", "+inf vs -inf");
    cmp(PINF, PINF, 32'd1, "R7", "+inf vs +inf");
  endtask

  task automatic t_sticky;
    set_status(6'h0);
    cmp(DN1, P1, 32'd0, "R4", "flush for sticky");
    cmp(P3, P3, 32'd1, "R8", "clean op after flag");
    repeat (5) @(negedge clk);
    chk(status === 6'h20, "R8", "bit held idle", {26'h0, status}, 32'h20);
    set_status(6'h0);
    chk(status === 6'h0, "R8", "explicit clear", {26'h0, status}, 32'h0);
  endtask

  task automatic t_merge;
    set_status(6'h0);
    issue(P1, DN1, 1'b1, 6'h04, 1'b0, 6'h0, 1'b1);
    chk(status === 6'h24, "R9", "own|ext merge", {26'h0, status}, 32'h24);
    issue(PZ, PZ, 1'b0, 6'h0A, 1'b0, 6'h0, 1'b0);
    chk(status === 6'h2E, "R9", "ext only merge", {26'h0, status}, 32'h2E);
    issue(P1, P1, 1'b0, 6'h10, 1'b0, 6'h0, 1'b1);
    chk(status === 6'h3E, "R9", "ext merge guard off", {26'h0, status}, 32'h3E);
  endtask

  task automatic t_priority;
    set_status(6'h3F);
    issue(SN, DN1, 1'b1, 6'h3F, 1'b1, 6'h02, 1'b1);
    chk(status === 6'h02, "R10", "write beats updates", {26'h0, status}, 32'h2);
    chk(res_data === 32'd0, "R10", "result still written", res_data, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_guard;
    t_denorm;
    t_nan;
    t_inf;
    t_sticky;
    t_merge;
    t_priority;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule